// File: doc/BRIEF.md
# Host Session Window Controller

This controller sits between a capacitive sensing engine and an I2C target interface. After every sensing cycle it decides whether to offer the host a session. When it does, it raises the active-high ready line and holds the window open. The window closes when the host issues an end-of-session command, or when a programmable millisecond limit runs out, so that sensing can continue without a responsive host.

In event mode the window is offered only when at least one enabled class of change has happened since the last window closed. Otherwise the cycle passes silently. The classes are: movement, proximity, touch, snap, recalibration, low-power proximity, and a change on the switch pin. The host may also address the device when no window is open. While the device sleeps, the first addressing is refused. Once a wake guard time has passed after that STOP, a retry is accepted. An accepted forced access stretches the clock until the next end of a sensing cycle, which is the safe point, and the ready line stays low throughout.

Top module: `comm_window_ctrl`

## Requirements
- R1: After reset, rdy and stretch are 0, swState and recalFlag are 0, and addrAck is 1 while lowPower is 0.
- R2: With eventMode at 0, a cycleDone pulse while no session is active raises rdy on the next clock edge.
- R3: With eventMode at 1, a window opens only if some pending event bit is also set in evEnable. The event bits are: 0 movement, 1 proximity, 2 touch, 3 snap, 4 recalibration, 5 low-power proximity and 6 switch change. Bits 0 to 5 come from changeIn.
- R4: Event bits latch from the moment they occur until a window closes, and closing a window clears them.
- R5: endCmd during a window drops rdy on the next edge, and an I2C STOP alone leaves the window open.
- R6: With timeoutMs = T > 0, a window that is not ended holds rdy for exactly T*CLK_PER_US*US_PER_MS+1 clocks, and T = 0 keeps it open until endCmd.
- R7: On each cycleDone, swState takes swPin XOR swActiveLow, and swState does not change between cycleDone pulses. A sampled change sets event bit 6.
- R8: recalFlag is set at the cycleDone that ends a sensing cycle in which changeIn[4] pulsed. It stays set for exactly one sensing cycle, up to the next cycleDone.
- R9: While lowPower is 1, addrAck is 0. After a refused addressing, addrAck becomes 1 WAKE_US*CLK_PER_US clocks after the following STOP.
- R10: An accepted addressing while no session is active raises stretch until the next cycleDone, keeps rdy at 0, and ends at the next STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cycleDone | input | 1 | Strobe at the end of a sensing cycle |
| changeIn | input | 6 | Change strobes for event classes 0 to 5 |
| evEnable | input | 7 | Per-class event enables |
| eventMode | input | 1 | 1: open windows only on enabled events |
| swPin | input | 1 | Switch input pin |
| swActiveLow | input | 1 | 1: switch is active when the pin is low |
| timeoutMs | input | TO_W | Window limit in ms; 0 disables the limit |
| lowPower | input | 1 | Device is in its low-power state |
| addrMatch | input | 1 | Target interface saw its own address |
| i2cStop | input | 1 | STOP condition seen |
| endCmd | input | 1 | End-of-session command decoded |
| rdy | output | 1 | Session window open |
| stretch | output | 1 | Hold SCL low |
| addrAck | output | 1 | Acknowledge an address match |
| swState | output | 1 | Sampled switch state, 1 = active |
| recalFlag | output | 1 | Recalibration occurred in the last cycle |

## Verification
The bench builds the block with CLK_PER_US = 2, US_PER_MS = 3 and WAKE_US = 4. This gives a 6-clock millisecond and an 8-clock wake guard. With these values an exact 13-clock count for a 2 ms window is affordable, and so is a before-and-after probe of the guard expiry. A 40-clock wait is then long enough to show that a zero limit never closes a window.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int EV_NUM    = 7;
  localparam int EV_RECAL  = 4;
  localparam int EV_SWITCH = 6;

  typedef enum logic [1:0] {
    ST_SENSE  = 2'd0,
    ST_WINDOW = 2'd1,
    ST_FWAIT  = 2'd2,
    ST_FXFER  = 2'd3
  } cwState_e;

  typedef struct packed {
    logic openWin;
    logic closeWin;
  } cwStrobe_t;
endpackage

// File: rtl/cw_datapath.sv
module cw_datapath
  import cw_pkg::*;
#(
  parameter int CLK_PER_MS = 100000,
  parameter int WAKE_CYC   = 15000,
  parameter int TO_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleDone,
  input  logic [5:0]        changeIn,
  input  logic [EV_NUM-1:0] evEnable,
  input  logic              eventMode,
  input  logic              swPin,
  input  logic              swActiveLow,
  input  logic [TO_W-1:0]   timeoutMs,
  input  logic              lowPower,
  input  logic              addrMatch,
  input  logic              i2cStop,
  input  cwStrobe_t         strb,
  input  logic              inWindow,
  output logic              wantWindow,
  output logic              expired,
  output logic              ackOk,
  output logic              swState,
  output logic              recalFlag
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam int GRD_W = $clog2(WAKE_CYC + 1);

  logic              swNow;
  logic [EV_NUM-1:0] newEv;
  logic [EV_NUM-1:0] pending;
  logic              recalCur;
  logic [PRE_W-1:0]  preCnt;
  logic [TO_W-1:0]   msCnt;
  logic              nackPend;
  logic              guardRun;
  logic [GRD_W-1:0]  guardCnt;
  logic              wakeArmed;
  logic              refuse;

  assign swNow      = swPin ^ swActiveLow;
  assign newEv      = {cycleDone && (swNow != swState), changeIn};
  assign wantWindow = !eventMode || (|((pending | newEv) & evEnable));
  assign expired    = inWindow && (timeoutMs != '0) && (msCnt == timeoutMs);
  assign ackOk      = !lowPower || wakeArmed;
  assign refuse     = addrMatch && !ackOk;

  // event latch: new events win over a clear in the same clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= '0;
    else       pending <= (strb.closeWin ? '0 : pending) | newEv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swState   <= 1'b0;
      recalCur  <= 1'b0;
      recalFlag <= 1'b0;
    end else if (cycleDone) begin
      swState   <= swNow;
      recalFlag <= recalCur | changeIn[EV_RECAL];
      recalCur  <= 1'b0;
    end else begin
      recalCur  <= recalCur | changeIn[EV_RECAL];
    end
  end

  // window timer: prescaler to milliseconds, saturating ms count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (strb.openWin) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (inWindow) begin
      if (preCnt == PRE_W'(CLK_PER_MS - 1)) begin
        preCnt <= '0;
        if (msCnt != '1) msCnt <= msCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // wake guard after a refused addressing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nackPend  <= 1'b0;
      guardRun  <= 1'b0;
      guardCnt  <= '0;
      wakeArmed <= 1'b0;
    end else if (!lowPower) begin
      nackPend  <= 1'b0;
      guardRun  <= 1'b0;
      guardCnt  <= '0;
      wakeArmed <= 1'b0;
    end else if (i2cStop && (nackPend || refuse)) begin
      nackPend  <= 1'b0;
      guardRun  <= 1'b1;
      guardCnt  <= '0;
    end else begin
      if (refuse) nackPend <= 1'b1;
      if (guardRun) begin
        if (guardCnt == GRD_W'(WAKE_CYC - 1)) begin
          guardRun  <= 1'b0;
          wakeArmed <= 1'b1;
        end else begin
          guardCnt <= guardCnt + 1'b1;
        end
      end
    end
  end

  // R9: acceptance while asleep only follows a running guard
  p_wake_after_guard_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ackOk) && lowPower) |-> $past(guardRun));

  // R8: the recalibration flag only moves at a cycle boundary
  p_recal_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(recalFlag) |-> $past(cycleDone));

  // R7: the switch state only moves at a cycle boundary
  p_sw_sample_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(swState) |-> $past(cycleDone));
endmodule

// File: rtl/cw_control.sv
module cw_control
  import cw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cycleDone,
  input  logic      wantWindow,
  input  logic      expired,
  input  logic      endCmd,
  input  logic      i2cStop,
  input  logic      addrMatch,
  input  logic      ackOk,
  output cwStrobe_t strb,
  output logic      rdy,
  output logic      stretch,
  output logic      inWindow
);
  cwState_e state, stateNxt;

  always_comb begin
    stateNxt      = state;
    strb.openWin  = 1'b0;
    strb.closeWin = 1'b0;
    unique case (state)
      ST_SENSE: begin
        if (addrMatch && ackOk) begin
          stateNxt = cycleDone ? ST_FXFER : ST_FWAIT;
        end else if (cycleDone && wantWindow) begin
          stateNxt     = ST_WINDOW;
          strb.openWin = 1'b1;
        end
      end
      ST_WINDOW: begin
        if (endCmd || expired) begin
          stateNxt      = ST_SENSE;
          strb.closeWin = 1'b1;
        end
      end
      ST_FWAIT: if (cycleDone) stateNxt = ST_FXFER;
      ST_FXFER: if (i2cStop || endCmd) stateNxt = ST_SENSE;
      default:  stateNxt = ST_SENSE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SENSE;
    else       state <= stateNxt;
  end

  assign rdy      = (state == ST_WINDOW);
  assign inWindow = rdy;
  assign stretch  = (state == ST_FWAIT);

  // R2: a window only opens right after a cycle ends
  p_open_after_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdy) |-> $past(cycleDone));

  // R5: end command closes, a bare STOP does not
  p_end_closes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdy && endCmd) |=> !rdy);
  p_stop_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdy && i2cStop && !endCmd && !expired) |=> rdy);

  // R6: an expired limit closes the window
  p_timeout_closes_r6: assert property (@(posedge clk) disable iff (!rstN)
    expired |=> !rdy);

  // R10: a stretched access never shows ready
  p_force_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    stretch |=> !rdy);
endmodule

// File: rtl/comm_window_ctrl.sv
module comm_window_ctrl
  import cw_pkg::*;
#(
  parameter int CLK_PER_US = 100,
  parameter int US_PER_MS  = 1000,
  parameter int WAKE_US    = 150,
  parameter int TO_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleDone,
  input  logic [5:0]        changeIn,
  input  logic [EV_NUM-1:0] evEnable,
  input  logic              eventMode,
  input  logic              swPin,
  input  logic              swActiveLow,
  input  logic [TO_W-1:0]   timeoutMs,
  input  logic              lowPower,
  input  logic              addrMatch,
  input  logic              i2cStop,
  input  logic              endCmd,
  output logic              rdy,
  output logic              stretch,
  output logic              addrAck,
  output logic              swState,
  output logic              recalFlag
);
  localparam int CLK_PER_MS = CLK_PER_US * US_PER_MS;
  localparam int WAKE_CYC   = CLK_PER_US * WAKE_US;

  cwStrobe_t strb;
  logic      inWindow;
  logic      wantWindow;
  logic      expired;
  logic      ackOk;

  cw_control ctrl_i (
    .clk(clk), .rstN(rstN), .cycleDone(cycleDone), .wantWindow(wantWindow),
    .expired(expired), .endCmd(endCmd), .i2cStop(i2cStop),
    .addrMatch(addrMatch), .ackOk(ackOk), .strb(strb), .rdy(rdy),
    .stretch(stretch), .inWindow(inWindow)
  );

  cw_datapath #(.CLK_PER_MS(CLK_PER_MS), .WAKE_CYC(WAKE_CYC), .TO_W(TO_W)) dp_i (
    .clk(clk), .rstN(rstN), .cycleDone(cycleDone), .changeIn(changeIn),
    .evEnable(evEnable), .eventMode(eventMode), .swPin(swPin),
    .swActiveLow(swActiveLow), .timeoutMs(timeoutMs), .lowPower(lowPower),
    .addrMatch(addrMatch), .i2cStop(i2cStop), .strb(strb),
    .inWindow(inWindow), .wantWindow(wantWindow), .expired(expired),
    .ackOk(ackOk), .swState(swState), .recalFlag(recalFlag)
  );

  assign addrAck = ackOk;
endmodule

// File: tb/comm_window_ctrl_tb_top.sv
module comm_window_ctrl_tb_top;
  localparam int TO_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycleDone = 1'b0;
  logic [5:0] changeIn = '0;
  logic [6:0] evEnable = '0;
  logic eventMode = 1'b0;
  logic swPin = 1'b0;
  logic swActiveLow = 1'b0;
  logic [TO_W-1:0] timeoutMs = '0;
  logic lowPower = 1'b0;
  logic addrMatch = 1'b0;
  logic i2cStop = 1'b0;
  logic endCmd = 1'b0;
  logic rdy, stretch, addrAck, swState, recalFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  comm_window_ctrl #(.CLK_PER_US(2), .US_PER_MS(3), .WAKE_US(4), .TO_W(TO_W)) dut_i (
    .clk(clk), .rstN(rstN), .cycleDone(cycleDone), .changeIn(changeIn),
    .evEnable(evEnable), .eventMode(eventMode), .swPin(swPin),
    .swActiveLow(swActiveLow), .timeoutMs(timeoutMs), .lowPower(lowPower),
    .addrMatch(addrMatch), .i2cStop(i2cStop), .endCmd(endCmd), .rdy(rdy),
    .stretch(stretch), .addrAck(addrAck), .swState(swState),
    .recalFlag(recalFlag)
  );

  // {changeIn[5:0], swFlip, evEnable[6:0], expectOpen}
  localparam logic [14:0] VEC [0:8] = '{
    {6'b000001, 1'b0, 7'b0000001, 1'b1},
    {6'b000010, 1'b0, 7'b0000001, 1'b0},
    {6'b000100, 1'b0, 7'b0000100, 1'b1},
    {6'b001000, 1'b0, 7'b1110111, 1'b0},
    {6'b010000, 1'b0, 7'b0010000, 1'b1},
    {6'b100000, 1'b0, 7'b0100000, 1'b1},
    {6'b000000, 1'b1, 7'b1000000, 1'b1},
    {6'b000000, 1'b1, 7'b0111111, 1'b0},
    {6'b000000, 1'b0, 7'b1111111, 1'b0}
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseCycle();
    cycleDone = 1'b1; @(negedge clk); cycleDone = 1'b0;
  endtask
  task automatic pulseEnd();
    endCmd = 1'b1; @(negedge clk); endCmd = 1'b0;
  endtask
  task automatic pulseStop();
    i2cStop = 1'b1; @(negedge clk); i2cStop = 1'b0;
  endtask
  task automatic pulseAddr();
    addrMatch = 1'b1; @(negedge clk); addrMatch = 1'b0;
  endtask
  task automatic pulseChange(logic [5:0] ev);
    changeIn = ev; @(negedge clk); changeIn = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdy", rdy, 0);
    check("R1 stretch", stretch, 0);
    check("R1 addrAck", addrAck, 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 swState", swState, 0);
    check("R1 recalFlag", recalFlag, 0);

    // R3 table of event patterns in event mode
    for (int i = 0; i < 9; i++) begin
      eventMode = 1'b1;
      evEnable  = VEC[i][7:1];
      if (VEC[i][14:9] != '0) pulseChange(VEC[i][14:9]);
      if (VEC[i][8]) swPin = ~swPin;
      pulseCycle();
      check($sformatf("R3 vector %0d", i), rdy, int'(VEC[i][0]));
      if (rdy) pulseEnd();
      eventMode = 1'b0;
      pulseCycle();
      pulseEnd();
    end

    // R2 plain mode opens every cycle
    pulseCycle();
    check("R2 open without events", rdy, 1);
    pulseEnd();

    // R4 latch across idle clocks, cleared by close
    eventMode = 1'b1;
    evEnable  = 7'b0000001;
    pulseChange(6'b000001);
    repeat (5) @(negedge clk);
    pulseCycle();
    check("R4 latched event opens", rdy, 1);
    pulseEnd();
    pulseCycle();
    check("R4 cleared after close", rdy, 0);
    eventMode = 1'b0;

    // R5 STOP keeps window, end command closes it
    pulseCycle();
    pulseStop();
    check("R5 stop keeps window", rdy, 1);
    pulseEnd();
    check("R5 end closes", rdy, 0);

    // R6 timeout of 2 ms = 12 clocks, window lasts 13 clocks
    timeoutMs = 8'd2;
    pulseCycle();
    begin
      int cnt = 0;
      while (rdy && cnt < 100) begin
        cnt++;
        @(negedge clk);
      end
      check("R6 window length", cnt, 13);
    end
    timeoutMs = '0;
    pulseCycle();
    repeat (40) @(negedge clk);
    check("R6 zero limit stays open", rdy, 1);
    pulseEnd();

    // R7 switch sampling with active-low polarity
    swActiveLow = 1'b1;
    swPin = 1'b1;
    pulseCycle();
    pulseEnd();
    check("R7 inactive pin", swState, 0);
    swPin = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 held between cycles", swState, 0);
    pulseCycle();
    check("R7 active-low sampled", swState, 1);
    pulseEnd();

    // R8 recalibration flag for one sensing cycle
    pulseChange(6'b010000);
    pulseCycle();
    check("R8 flag set", recalFlag, 1);
    pulseEnd();
    repeat (4) @(negedge clk);
    check("R8 flag held in cycle", recalFlag, 1);
    pulseCycle();
    check("R8 flag cleared next cycle", recalFlag, 0);
    pulseEnd();

    // R9 low-power refusal and wake guard
    lowPower = 1'b1;
    @(negedge clk);
    check("R9 asleep nack", addrAck, 0);
    pulseAddr();
    check("R9 refused no stretch", stretch, 0);
    pulseStop();
    repeat (3) @(negedge clk);
    check("R9 still guarded", addrAck, 0);
    repeat (6) @(negedge clk);
    check("R9 retry accepted", addrAck, 1);
    pulseAddr();
    check("R9 accepted access stretches", stretch, 1);
    pulseCycle();
    pulseStop();
    lowPower = 1'b0;

    // R10 forced access while no window
    @(negedge clk);
    pulseAddr();
    check("R10 stretch", stretch, 1);
    check("R10 no rdy while stretched", rdy, 0);
    pulseCycle();
    check("R10 released at safe point", stretch, 0);
    check("R10 no rdy in transfer", rdy, 0);
    pulseStop();
    pulseCycle();
    check("R10 normal window after stop", rdy, 1);
    pulseEnd();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule